// File: doc/BRIEF.md
# Synchronous Serial Transmitter with Restart Window

This block drains a block of 16-bit words from memory and sends them as a continuous synchronous bit stream towards a modem. Software loads a start address and a negative word count, then pulses `go`. The block fetches words one at a time over a request/grant port and holds one word ahead in a prefetch buffer. It breaks each word into two characters and shifts them onto `txd`, one bit for each `bit_tick` strobe from the line clock. It raises Request to Send on start and waits for Clear to Send before the first bit goes out.

Completion is flagged when the last word is fetched, not when it has been sent. Software therefore has the two character times of that last word to load a new address and count and pulse `go` again. The stream then continues with no idle bits between the two blocks. If the memory side cannot supply a word within one bit time while the line is running, the transfer is aborted and a sticky late flag is set. A separate register bit drives Data Terminal Ready, whatever the transfer is doing.

Top module: `sync_tx_engine`

## Requirements
- R1: After reset `txd` is 1, and `rts`, `busy`, `done`, `data_late`, `irq`, `dtr` and `dma_req` are all 0.
- R2: A `go` pulse sets `busy` and `rts` and clears `done` and `data_late` on the next cycle. From that cycle `dma_req` is high with `dma_addr` equal to the address counter. `dma_req` is never high while `busy` is low.
- R3: While `cts` is low before a block starts, `txd` stays at 1 even if a word is buffered and `bit_tick` strobes arrive.
- R4: Each word goes out as its low-byte character and then its high-byte character, least significant bit first, one bit per `bit_tick`. A character is the low CHAR_BITS bits of its byte. Any higher bits of the byte are never sent.
- R5: With PARITY_EN=1, a parity bit follows each character. It makes the number of ones in character plus parity even when PARITY_ODD=0, and odd when PARITY_ODD=1.
- R6: `reg_wr` with `reg_sel`=1 loads the 15-bit address counter, and with `reg_sel`=2 loads the 12-bit word counter with minus the word count. Each granted fetch increments both counters, and the address wraps from 0x7FFF to 0. A count of -N fetches exactly N words.
- R7: On the grant that brings the word counter to zero, `busy` clears and `done` sets, while that last word is still to be sent. `irq` is high whenever `done` is 1 and `irq_mask` is 0.
- R8: If a new address, count and `go` arrive before the final bit of the last word has finished, the next block's first bit follows that final bit with no mark bits in between, and `rts` stays high.
- R9: Without a restart, the tick that ends the final bit returns `txd` to 1, and `rts` falls on the following cycle. `txd` is 1 whenever `rts` is 0.
- R10: A `bit_tick` that arrives while bits are being shifted and a fetch is still outstanding sets `data_late`, clears `busy`, sets `done`, returns `txd` to 1 and drops `rts`. A grant in that same cycle is discarded. `data_late` stays set until the next `go`.
- R11: `reg_wr` with `reg_sel`=0 copies `reg_wdata` bit 0 to `dtr`. The other data bits and the transfer state have no effect on `dtr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 terminal ready, 1 address, 2 word count |
| reg_wdata | input | 16 | Register write data |
| go | input | 1 | Start pulse: sets busy |
| irq_mask | input | 1 | Suppresses `irq` when 1 |
| busy | output | 1 | Fetching in progress |
| done | output | 1 | Block complete or aborted |
| data_late | output | 1 | Sticky fetch underrun flag |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | Fetch request |
| dma_addr | output | 15 | Address counter |
| dma_gnt | input | 1 | Fetch grant, data valid |
| dma_data | input | 16 | Fetched word |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| cts | input | 1 | Clear to Send from the modem |
| rts | output | 1 | Request to Send to the modem |
| txd | output | 1 | Serial data, mark when idle |
| dtr | output | 1 | Data Terminal Ready |

## Verification
The bench builds the block with 7-bit characters and even parity, so every frame is exactly 16 line bits. With this setting bits 7 and 15 of each word must be replaced by the generated parity bits, which exposes both a wrong character width and a wrong parity sense. Because the bench drives every bit tick itself, it can place a restart in the middle of the final character and an underrun on an exact tick. It also runs one block across the 15-bit address wrap.

// File: rtl/sync_tx_engine.sv
module sync_tx_engine #(
  parameter int CHAR_BITS  = 8,
  parameter int PARITY_EN  = 1,
  parameter bit PARITY_ODD = 1'b0,
  parameter int AW         = 15,
  parameter int WCW        = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_sel,
  input  logic [15:0]   reg_wdata,
  input  logic          go,
  input  logic          irq_mask,
  output logic          busy,
  output logic          done,
  output logic          data_late,
  output logic          irq,
  output logic          dma_req,
  output logic [AW-1:0] dma_addr,
  input  logic          dma_gnt,
  input  logic [15:0]   dma_data,
  input  logic          bit_tick,
  input  logic          cts,
  output logic          rts,
  output logic          txd,
  output logic          dtr
);
  localparam int CL    = CHAR_BITS + PARITY_EN;
  localparam int FRAME = 2 * CL;
  localparam int BCW   = $clog2(FRAME);

  logic [15:0]      wbuf;
  logic             bufv, sending;
  logic [FRAME-1:0] sh;
  logic [BCW-1:0]   bitn;
  logic [AW-1:0]    addr;
  logic [WCW-1:0]   wcnt;
  logic             unused_bits;

  function automatic logic [FRAME-1:0] pack(input logic [15:0] w);
    logic [CL-1:0] lo_f, hi_f;
    lo_f = '0;
    hi_f = '0;
    lo_f[CHAR_BITS-1:0] = w[CHAR_BITS-1:0];
    hi_f[CHAR_BITS-1:0] = w[8 +: CHAR_BITS];
    if (PARITY_EN != 0) begin
      lo_f[CL-1] = (^w[CHAR_BITS-1:0]) ^ PARITY_ODD;
      hi_f[CL-1] = (^w[8 +: CHAR_BITS]) ^ PARITY_ODD;
    end
    return {hi_f, lo_f};
  endfunction

  wire last_bit   = bitn == BCW'(FRAME - 1);
  wire late_hit   = bit_tick & sending & dma_req;
  wire take       = dma_req & dma_gnt & ~late_hit;
  wire final_word = take & (wcnt == '1);
  wire load       = bit_tick & bufv & (sending ? last_bit : (rts & cts));

  assign dma_req     = busy & ~bufv;
  assign dma_addr    = addr;
  assign txd         = ~sending | sh[0];
  assign irq         = done & ~irq_mask;
  assign unused_bits = ^{reg_wdata, dma_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      data_late <= 1'b0;
      rts       <= 1'b0;
      dtr       <= 1'b0;
      bufv      <= 1'b0;
      sending   <= 1'b0;
      wbuf      <= '0;
      sh        <= '0;
      bitn      <= '0;
      addr      <= '0;
      wcnt      <= '0;
    end else begin
      if (reg_wr && reg_sel == 2'd1)      addr <= reg_wdata[AW-1:0];
      else if (take)                      addr <= addr + 1'b1;
      if (reg_wr && reg_sel == 2'd2)      wcnt <= reg_wdata[WCW-1:0];
      else if (take)                      wcnt <= wcnt + 1'b1;
      if (reg_wr && reg_sel == 2'd0)      dtr  <= reg_wdata[0];

      if (take) begin
        wbuf <= dma_data;
        bufv <= 1'b1;
      end else if (load) begin
        bufv <= 1'b0;
      end

      if (late_hit) begin
        sending <= 1'b0;
      end else if (load) begin
        sh      <= pack(wbuf);
        bitn    <= '0;
        sending <= 1'b1;
      end else if (bit_tick && sending) begin
        if (last_bit) sending <= 1'b0;
        else begin
          sh   <= sh >> 1;
          bitn <= bitn + 1'b1;
        end
      end

      if (final_word) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
      if (late_hit) begin
        data_late <= 1'b1;
        busy      <= 1'b0;
        done      <= 1'b1;
        rts       <= 1'b0;
        bufv      <= 1'b0;
      end else if (!busy && !bufv && !sending) begin
        rts <= 1'b0;
      end
      if (go) begin
        busy      <= 1'b1;
        done      <= 1'b0;
        data_late <= 1'b0;
        rts       <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sync_tx_engine_chk.sv
module sync_tx_engine_chk #(
  parameter int AW = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [1:0]    reg_sel,
  input logic          wdat0,
  input logic          go,
  input logic          busy,
  input logic          done,
  input logic          data_late,
  input logic          dma_req,
  input logic [AW-1:0] dma_addr,
  input logic          dma_gnt,
  input logic          bit_tick,
  input logic          rts,
  input logic          txd,
  input logic          dtr
);
  AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (busy && rts && !done && !data_late)); // R2
  AST_REQ_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> busy); // R2
  AST_MARK_WITHOUT_RTS: assert property (@(posedge clk) disable iff (!rst_n)
    !rts |-> txd); // R9
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && dma_gnt && !bit_tick && !(reg_wr && reg_sel == 2'd1))
      |=> dma_addr == $past(dma_addr) + 1'b1); // R6
  AST_LATE_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_late) |-> (!busy && done && !rts)); // R10
  AST_LATE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (data_late && !go) |=> data_late); // R10
  AST_DTR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd0) |=> dtr == $past(wdat0)); // R11
endmodule

bind sync_tx_engine sync_tx_engine_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .wdat0(reg_wdata[0]), .go(go), .busy(busy), .done(done),
  .data_late(data_late), .dma_req(dma_req), .dma_addr(dma_addr),
  .dma_gnt(dma_gnt), .bit_tick(bit_tick), .rts(rts), .txd(txd), .dtr(dtr)
);

// File: tb/sync_tx_engine_tb_top.sv
module sync_tx_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] VEC [0:5] = '{
    32'h0000_0000, 32'h00FF_00FF, 32'h8001_0081,
    32'h0380_0300, 32'h5A3C_5A3C, 32'h7F07_FF87
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_wr = 1'b0, go = 1'b0, irq_mask = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [15:0] reg_wdata = '0, dma_data = '0;
  logic        dma_gnt = 1'b0, bit_tick = 1'b0, cts = 1'b0;
  logic        busy, done, data_late, irq, dma_req, rts, txd, dtr;
  logic [14:0] dma_addr;
  logic [15:0] mem [0:63];
  bit          gnt_on = 1'b0;
  int          nreads = 0, n_chk = 0, n_bad = 0;

  sync_tx_engine #(.CHAR_BITS(7), .PARITY_EN(1), .PARITY_ODD(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .go(go), .irq_mask(irq_mask), .busy(busy),
    .done(done), .data_late(data_late), .irq(irq), .dma_req(dma_req),
    .dma_addr(dma_addr), .dma_gnt(dma_gnt), .dma_data(dma_data),
    .bit_tick(bit_tick), .cts(cts), .rts(rts), .txd(txd), .dtr(dtr));

  always #(CLK_PERIOD/2) clk = ~clk;

  initial forever begin
    @(negedge clk);
    if (dma_gnt) dma_gnt = 1'b0;
    else if (dma_req && gnt_on) begin
      dma_gnt  = 1'b1;
      dma_data = mem[dma_addr[5:0]];
      nreads++;
    end
  end

  function automatic logic [15:0] exp_line(input logic [15:0] w);
    return {^w[14:8], w[14:8], ^w[6:0], w[6:0]};
  endfunction

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic pulse_go();
    @(negedge clk); go = 1'b1;
    @(negedge clk); go = 1'b0;
  endtask

  task automatic tick_bit(output logic b);
    @(negedge clk); bit_tick = 1'b1;
    @(negedge clk); bit_tick = 1'b0;
    b = txd;
    repeat (2) @(negedge clk);
  endtask

  task automatic get_word(output logic [15:0] s);
    logic b;
    for (int i = 0; i < 16; i++) begin
      tick_bit(b);
      s[i] = b;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    report();
  end

  initial begin
    logic [15:0] s;
    logic b;
    int base;
    for (int i = 0; i < 64; i++) mem[i] = 16'(i * 16'h0101);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 txd", txd, 1);
    chk("R1 flags", {rts, busy, done, data_late, irq, dtr, dma_req}, 0);

    wr(2'd0, 16'h0001);
    chk("R11 dtr set", dtr, 1);
    wr(2'd0, 16'hFFFE);
    chk("R11 dtr bit0 only", dtr, 0);
    wr(2'd0, 16'h0001);

    // table of words through one block
    for (int k = 0; k < 6; k++) mem[16 + k] = VEC[k][31:16];
    wr(2'd1, 16'd16);
    wr(2'd2, 16'h0FFA);
    pulse_go();
    chk("R2 armed", {busy, rts, done, data_late, dma_req}, 5'b11001);
    chk("R2 addr", dma_addr, 16);
    base = nreads;
    gnt_on = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      tick_bit(b);
      chk("R3 mark before cts", b, 1);
    end
    cts = 1'b1;
    for (int k = 0; k < 6; k++) begin
      get_word(s);
      chk("R4 R5 frame", s, VEC[k][15:0]);
      if (k == 3) chk("R7 not early", {done, busy}, 2'b01);
      if (k == 4) chk("R7 done at last fetch", {done, busy, irq, rts}, 4'b1011);
    end
    irq_mask = 1'b1;
    @(negedge clk);
    chk("R7 masked", irq, 0);
    irq_mask = 1'b0;
    chk("R9 rts held to end", rts, 1);
    tick_bit(b);
    chk("R9 mark after end", b, 1);
    chk("R9 rts dropped", rts, 0);
    chk("R6 word count", nreads - base, 6);
    chk("R6 address", dma_addr, 22);
    chk("R11 dtr unaffected", dtr, 1);

    // restart inside the window, second block across the address wrap
    mem[30] = 16'h1234; mem[31] = 16'hABCD; mem[63] = 16'h0F0F; mem[0] = 16'hF0F0;
    wr(2'd1, 16'd30);
    wr(2'd2, 16'h0FFE);
    pulse_go();
    repeat (4) @(negedge clk);
    get_word(s);
    chk("R8 first word", s, exp_line(16'h1234));
    chk("R7 done early", done, 1);
    for (int i = 0; i < 8; i++) begin
      tick_bit(b);
      s[i] = b;
    end
    wr(2'd1, 16'h7FFF);
    wr(2'd2, 16'h0FFE);
    pulse_go();
    repeat (4) @(negedge clk);
    for (int i = 8; i < 16; i++) begin
      tick_bit(b);
      s[i] = b;
    end
    chk("R8 last old word", s, exp_line(16'hABCD));
    get_word(s);
    chk("R8 seamless new word", s, exp_line(16'h0F0F));
    chk("R8 rts kept", rts, 1);
    get_word(s);
    chk("R8 second new word", s, exp_line(16'hF0F0));
    tick_bit(b);
    chk("R9 end state", {b, rts, busy, done, data_late}, 5'b10010);
    chk("R6 address wrap", dma_addr, 1);

    // fetch underrun
    mem[40] = 16'h0055; mem[41] = 16'h3C69; mem[42] = 16'h7E01;
    wr(2'd1, 16'd40);
    wr(2'd2, 16'h0FFD);
    pulse_go();
    repeat (4) @(negedge clk);
    gnt_on = 1'b0;
    tick_bit(b);
    chk("R10 first bit", b, 1);
    tick_bit(b);
    chk("R10 mark on abort", b, 1);
    chk("R10 abort state", {data_late, busy, done, rts}, 4'b1010);
    repeat (6) @(negedge clk);
    chk("R10 sticky", data_late, 1);
    chk("R7 irq", irq, 1);
    pulse_go();
    chk("R10 cleared by go", {data_late, busy, done}, 3'b010);
    gnt_on = 1'b1;
    repeat (4) @(negedge clk);
    get_word(s);
    chk("R10 resume word", s, exp_line(16'h3C69));
    get_word(s);
    chk("R10 resume last", s, exp_line(16'h7E01));
    tick_bit(b);
    chk("R9 idle", {b, rts, done}, 3'b101);
    report();
  end
endmodule